// File: doc/BRIEF.md
# Accumulator Multicycle Processor Sequencer

A small processor core built around a single accumulator. Each instruction goes through a fixed series of register transfers. First the program counter is copied into the memory address register and advanced by one. The addressed word is then read into the memory data register and moved into the instruction register. Decode splits that word into an opcode and an operand, and execute carries it out. The core drives one shared synchronous memory through a registered address, a write strobe and write data. Read data comes back one clock after the address is presented.

The instruction set covers load, add, store, unconditional jump, halt and return-from-interrupt. A single level-sensitive interrupt request is checked only when an execute step has finished. When the request is taken, the return address is pushed onto a downward-growing stack in memory, the interrupt-enable flag is cleared, and control passes to a fixed service-routine address. The return instruction pops the saved address and sets the enable flag again.

Top module: `acc_cpu`

## Requirements
- R1: After reset the core shows `pc_out` = RESET_PC (default 0), `acc_out` = 0 and `halted` = 0. The interrupt-enable flag is set and the stack pointer holds the highest address, 4095.
- R2: The program counter is advanced by one during fetch, before the instruction executes. A HALT fetched from address A leaves `pc_out` = A+1.
- R3: An instruction word is 16 bits. The opcode is in bits 15:12 and the operand address is in bits 11:0. Opcodes: 0 HALT, 1 LDA, 2 ADD, 3 STA, 4 JMP, 5 RETI.
- R4: LDA loads the accumulator with the memory word at the operand address.
- R5: ADD reads the memory word at the operand address in a second access and adds it to the accumulator, modulo 2^16. Starting from PC=100 with ACC=12, memory[100]=ADD 50 and memory[50]=7, the result is ACC=19 and PC=101.
- R6: STA writes the accumulator to memory at the operand address.
- R7: JMP loads the program counter with the operand, so execution continues there.
- R8: HALT stops the core. While halted, no further memory write is issued and `pc_out` and `acc_out` keep their values.
- R9: Opcodes 6 to 15 do nothing. The accumulator and memory are unchanged, and execution continues with the next word.
- R10: An interrupt is taken only after an execute step, and only while `irq` is high and interrupts are enabled. The return address is written to memory at the stack pointer and the stack pointer then decrements. The program counter becomes ISR_ADDR (default 0x800) and interrupts are disabled, so a request that stays high does not nest.
- R11: RETI increments the stack pointer, loads the program counter from that stack word and sets interrupts enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Memory address (registered) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after address |
| halted | output | 1 | Core has executed HALT |
| pc_out | output | 12 | Current program counter |
| acc_out | output | 16 | Current accumulator |

## Verification
A program of load, add, store and halt is run for every pair drawn from a set of operand values. The set includes zero, one, the sign boundary and all ones, so the pairs separate a correct modulo-2^16 sum from a wrong carry, a swapped operand and a missing second memory access. Further programs cover the worked trace after a jump, a skipped add after a jump, and an undefined opcode placed between real instructions. In the interrupt run, a counting loop is interrupted while the request is held high through the service routine. That run tells apart a correct return address, nested entry, a wrong stack slot and a failed return. The halt state is held for several cycles and watched for stray writes.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] ISR_ADDR = AW'(1) << (AW-1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] acc_out
);
  localparam int OPW = DW - AW;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC, S_RD, S_LD, S_EX, S_WR, S_INT, S_PUSH, S_HALT
  } state_t;

  state_t state;
  logic [AW-1:0] pc, mar, sp;
  logic [DW-1:0] mdr, cir, acc;
  logic ie;

  wire [OPW-1:0] opcode  = cir[DW-1:AW];
  wire [AW-1:0]  operand = cir[AW-1:0];

  assign mem_addr  = mar;
  assign mem_we    = (state == S_WR) || (state == S_PUSH);
  assign mem_wdata = mdr;
  assign halted    = (state == S_HALT);
  assign pc_out    = pc;
  assign acc_out   = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_F0;
      pc <= RESET_PC;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
      sp <= '1;
      ie <= 1'b1;
    end else begin
      case (state)
        S_F0: begin mar <= pc; pc <= pc + 1'b1; state <= S_F1; end
        S_F1: state <= S_F2;
        S_F2: begin mdr <= mem_rdata; state <= S_F3; end
        S_F3: begin cir <= mdr; state <= S_DEC; end
        S_DEC: begin
          case (opcode)
            OPW'(0): state <= S_HALT;
            OPW'(1), OPW'(2): begin mar <= operand; state <= S_RD; end
            OPW'(3): begin mar <= operand; mdr <= acc; state <= S_WR; end
            OPW'(4): begin pc <= operand; state <= S_INT; end
            OPW'(5): begin sp <= sp + 1'b1; mar <= sp + 1'b1; state <= S_RD; end
            default: state <= S_INT;
          endcase
        end
        S_RD: state <= S_LD;
        S_LD: begin mdr <= mem_rdata; state <= S_EX; end
        S_EX: begin
          case (opcode)
            OPW'(1): acc <= mdr;
            OPW'(2): acc <= acc + mdr;
            default: begin pc <= mdr[AW-1:0]; ie <= 1'b1; end
          endcase
          state <= S_INT;
        end
        S_WR: state <= S_INT;
        S_INT: begin
          if (irq && ie) begin
            mar <= sp;
            mdr <= DW'(pc);
            sp <= sp - 1'b1;
            pc <= ISR_ADDR;
            ie <= 1'b0;
            state <= S_PUSH;
          end else begin
            state <= S_F0;
          end
        end
        S_PUSH: state <= S_F0;
        default: state <= S_HALT;
      endcase
    end
  end

  assert_pc_changes_at_known_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> ($past(state) == S_F0 || $past(state) == S_DEC ||
                      $past(state) == S_EX || $past(state) == S_INT));

  assert_acc_changes_in_execute_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc) |-> $past(state) == S_EX);

  assert_cir_from_mdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_F3 |=> cir == $past(mdr));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(pc) && $stable(acc));

  assert_push_below_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PUSH |-> (mem_addr == sp + 1'b1) && !ie && pc == ISR_ADDR);

  assert_ie_falls_on_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> $past(state) == S_INT && $past(irq));

  assert_ie_rises_on_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie) |-> $past(state) == S_EX && $past(opcode) == OPW'(5));
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, irq = 0;
  logic [11:0] mem_addr;
  logic mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic halted;
  logic [11:0] pc_out;
  logic [15:0] acc_out;
  logic [15:0] mem [0:4095];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .pc_out(pc_out), .acc_out(acc_out));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic start();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    check({req, " halt reached"}, halted, 1);
  endtask

  initial begin
    int vals [6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [15:0] ret;

    // R1 reset state
    clear_mem();
    @(negedge clk); @(negedge clk);
    check("R1 pc", pc_out, 0);
    check("R1 acc", acc_out, 0);
    check("R1 halted", halted, 0);
    check("R1 we", mem_we, 0);

    // R4 R5 R6 R3 sweep over operand pairs
    foreach (vals[i]) foreach (vals[j]) begin
      clear_mem();
      mem[0] = ins(1, 40); mem[1] = ins(2, 41); mem[2] = ins(3, 200); mem[3] = ins(0, 0);
      mem[40] = vals[i][15:0]; mem[41] = vals[j][15:0];
      start();
      run_to_halt("R5");
      check("R5 add sum", acc_out, 32'((vals[i] + vals[j]) & 16'hFFFF));
      check("R6 store", mem[200], 32'((vals[i] + vals[j]) & 16'hFFFF));
      check("R4 load kept source", mem[40], 32'(vals[i][15:0]));
      check("R2 halt pc", pc_out, 4);
    end

    // R5 R7 worked trace: PC=100, ADD 50, mem[50]=7, ACC=12
    clear_mem();
    mem[0] = ins(1, 52); mem[1] = ins(4, 100); mem[52] = 12; mem[50] = 7;
    mem[100] = ins(2, 50); mem[101] = ins(0, 0);
    start();
    run_to_halt("R7");
    check("R5 trace acc", acc_out, 19);
    check("R2 trace pc", pc_out, 102);

    // R7 jump skips an add; R9 undefined opcodes are no-ops
    clear_mem();
    mem[0] = ins(1, 60); mem[1] = ins(9, 61); mem[2] = ins(15, 62); mem[3] = ins(4, 5);
    mem[4] = ins(2, 60); mem[5] = ins(6, 60); mem[6] = ins(0, 0);
    mem[60] = 16'h00AB; mem[61] = 16'h1111; mem[62] = 16'h2222;
    start();
    run_to_halt("R9");
    check("R7 jump skipped add", acc_out, 16'h00AB);
    check("R9 nop no write", mem[61], 16'h1111);
    check("R9 nop no write 2", mem[62], 16'h2222);
    check("R9 nop no write 3", mem[60], 16'h00AB);
    check("R2 nop path pc", pc_out, 7);

    // R8 halt holds
    repeat (20) begin
      @(negedge clk);
      if (mem_we || !halted || pc_out != 7) check("R8 halted stable", {mem_we, halted, pc_out}, {1'b0, 1'b1, 12'd7});
    end
    check("R8 halt still", halted, 1);

    // R10 R11 interrupt entry, no nesting, return
    clear_mem();
    for (int k = 0; k < 10; k++) mem[k] = ins(2, 61);
    mem[10] = ins(0, 0); mem[61] = 1;
    mem[12'h800] = ins(3, 300); mem[12'h801] = ins(5, 0);
    mem[4094] = 16'hDEAD;
    start();
    repeat (60) @(negedge clk);
    irq = 1;
    begin
      int n = 0;
      while (pc_out != 12'h802 && n < 2000) begin @(negedge clk); n++; end
    end
    irq = 0;
    run_to_halt("R11");
    ret = mem[4095];
    checks++;
    if (ret < 1 || ret > 9) begin failures++; $display("FAIL R10 return addr actual=%0h expected=1..9", ret); end
    check("R10 isr store equals adds done", mem[300], 32'(ret));
    check("R10 no nested push", mem[4094], 16'hDEAD);
    check("R11 resumed loop acc", acc_out, 10);
    check("R11 halt pc", pc_out, 11);

    done = 1;
  end

  initial begin
    int c = 0;
    while (!done && c < 150000) begin @(negedge clk); c++; end
    if (!done) begin checks++; failures++; $display("FAIL watchdog actual=timeout expected=done"); end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule